// File: doc/BRIEF.md
# Serial Flash Configuration Loader

This block reads a configuration image out of an external serial flash and then carries the device through a counted start-up phase. It first selects the flash with an active-low select line. It then sends a read command and a start address on its serial output and collects the returned image bits on its serial input. All of this is paced by a serial clock that the block generates from its own system clock. Each complete byte of the image is presented on a byte port with a one-cycle valid strobe. A downstream configuration store can pick the bytes up from there.

When the last image bit has been taken in, the block stops pulling the shared open-drain done line low. Start-up does not begin at that moment. It begins only once the done line is actually seen high through a synchronizer. Start-up then counts a fixed number of initialization clock periods and raises the user-mode flag. The initialization clock is either the system clock (the default) or an external user clock. When the external clock is chosen, a fixed settling delay comes first. Once user mode is reached, the block deselects the flash and lets go of the serial clock and data outputs.

Top module: `flash_cfg_loader`

## Requirements
- R1: While the image is being read, the serial clock idles high, toggles every SCLK_HALF system clock cycles (a period of 2*SCLK_HALF cycles), and falls only while the select line is low.
- R2: The select output `cs_n` is high during reset, low from the second cycle after reset release until user mode, and high again in user mode.
- R3: The serial output carries 32 bits, MSB first: the read command 0x03 in the upper 8 bits and a zero 24-bit address below it. Each bit changes only on a falling serial clock edge and is stable on the rising edge that follows.
- R4: Image bit j (j from 0) is put on the serial input by the flash at falling edge 32+j and captured by the block at falling edge 33+j, with edges counted from 0. Every 8 captured bits form one byte, the first captured bit in bit 7. Exactly NUM_BYTES bytes appear on `cfg_byte` with a one-cycle `cfg_valid`, in flash order.
- R5: `done_oe` is 1 (pulling the done line low) from reset until the last image bit is captured. It then drops to 0 and never returns to 1 before the next reset.
- R6: While `done_in` stays low after the image is loaded, start-up does not begin: `user_mode` stays 0 and `cs_n` stays low.
- R7: With `use_usr_clk` = 0, `user_mode` rises at the 3+INIT_CYCLES-th rising system clock edge after `done_in` goes high. This is two synchronizer edges, one decision edge and INIT_CYCLES counted cycles.
- R8: With `use_usr_clk` = 1, DELAY_CYCLES system cycles pass after the done line is sensed high. Then INIT_CYCLES rising edges of `usr_clk` are counted before `user_mode` rises. Edges that arrive during loading or during the delay are not counted, and INIT_CYCLES-1 counted edges are not enough.
- R9: In user mode `cs_n` is 1 and both `sclk_oe` and `mosi_oe` are 0. `user_mode` stays 1 until reset.
- R10: In reset, `user_mode` and `cfg_valid` are 0 and `sclk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the internal initialization clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_usr_clk | input | 1 | 1 selects `usr_clk` as the initialization clock |
| usr_clk | input | 1 | User-supplied initialization clock, sampled through a synchronizer |
| done_in | input | 1 | Sensed level of the open-drain done line |
| miso | input | 1 | Serial data returned by the flash |
| cs_n | output | 1 | Active-low flash select |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pad |
| mosi_o | output | 1 | Serial command/address output |
| mosi_oe | output | 1 | Output enable for the serial output pad |
| done_oe | output | 1 | 1 pulls the done line low; 0 releases it |
| cfg_byte | output | 8 | Assembled image byte |
| cfg_valid | output | 1 | One-cycle strobe for `cfg_byte` |
| user_mode | output | 1 | Start-up finished, device in user mode |

## Verification
A behavioural flash model answers the read with several byte patterns. These are an arithmetic ramp under different offsets and an alternating all-zeros/all-ones pattern. Together they show whether bits come out in the wrong order within a byte, whether a bit or a byte is lost or shifted, and whether capture happens one falling edge too early. Every pattern is run once with the internal initialization clock and once with the user clock. In the internal-clock runs the user-mode edge is pinned to its exact cycle. In the user-clock runs, stray user-clock edges are placed during loading and inside the delay window, and the bench then checks that one edge short of the count leaves the block waiting. The done line is also held low for a while after loading, to tell releasing the line apart from sensing it high.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT_DONE,
        ST_DELAY,
        ST_INIT,
        ST_USER
    } ld_state_e;

    localparam int CMD_BITS = 32;
    localparam logic [CMD_BITS-1:0] READ_CMD_WORD = {8'h03, 24'h000000};

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cfgld_half_timer.sv
module cfgld_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!en)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/cfgld_byte_pack.sv
module cfgld_byte_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    output logic [7:0] byte_o,
    output logic       byte_vld
);
    typedef struct packed {
        logic [6:0] sr;
        logic [2:0] pos;
        logic [7:0] byte_out;
        logic       vld;
    } pack_t;

    pack_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (bit_vld) begin
            d.sr  = {q.sr[5:0], bit_in};
            d.pos = q.pos + 1'b1;
            if (q.pos == 3'd7) begin
                d.byte_out = {q.sr, bit_in};
                d.vld      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_o   = q.byte_out;
    assign byte_vld = q.vld;
endmodule

// File: rtl/flash_cfg_loader.sv
module flash_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int NUM_BYTES    = 16,
    parameter int SCLK_HALF    = 2,
    parameter int DELAY_CYCLES = 120,
    parameter int INIT_CYCLES  = 4436
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       use_usr_clk,
    input  logic       usr_clk,
    input  logic       done_in,
    input  logic       miso,
    output logic       cs_n,
    output logic       sclk_o,
    output logic       sclk_oe,
    output logic       mosi_o,
    output logic       mosi_oe,
    output logic       done_oe,
    output logic [7:0] cfg_byte,
    output logic       cfg_valid,
    output logic       user_mode
);
    localparam int DATA_BITS = NUM_BYTES * 8;
    localparam int LAST_FALL = CMD_BITS + DATA_BITS;
    localparam int FALL_W    = $clog2(LAST_FALL + 1);
    localparam int CNT_MAX   = (INIT_CYCLES > DELAY_CYCLES) ? INIT_CYCLES : DELAY_CYCLES;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    localparam logic [FALL_W-1:0] CMD_END  = FALL_W'(CMD_BITS);
    localparam logic [FALL_W-1:0] LAST_IDX = FALL_W'(LAST_FALL);
    localparam logic [CNT_W-1:0]  DLY_END  = CNT_W'(DELAY_CYCLES);
    localparam logic [CNT_W-1:0]  INIT_END = CNT_W'(INIT_CYCLES);

    typedef struct packed {
        ld_state_e             state;
        logic                  sclk;
        logic                  mosi;
        logic [CMD_BITS-1:0]   cmd_sr;
        logic [FALL_W-1:0]     fall_cnt;
        logic [CNT_W-1:0]      cnt;
        logic                  usr_sel;
        logic                  usr_prev;
    } ctl_t;

    ctl_t q, d;
    logic half_tick;
    logic done_s;
    logic usr_s;
    logic cap_bit;
    logic usr_edge;

    cfgld_half_timer #(.HALF(SCLK_HALF)) i_half_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.state == ST_LOAD),
        .tick  (half_tick)
    );

    cfgld_sync #(.STAGES(2)) i_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (done_in),
        .dout  (done_s)
    );

    cfgld_sync #(.STAGES(2)) i_usr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (usr_clk),
        .dout  (usr_s)
    );

    cfgld_byte_pack i_byte_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (cap_bit),
        .bit_in   (miso),
        .byte_o   (cfg_byte),
        .byte_vld (cfg_valid)
    );

    assign usr_edge = usr_s && !q.usr_prev;

    always_comb begin
        d          = q;
        cap_bit    = 1'b0;
        d.usr_prev = usr_s;
        unique case (q.state)
            ST_IDLE: begin
                d.state = ST_LOAD;
            end
            ST_LOAD: begin
                if (half_tick) begin
                    d.sclk = ~q.sclk;
                    if (q.sclk) begin
                        // a falling serial clock edge happens on this cycle
                        d.fall_cnt = q.fall_cnt + 1'b1;
                        if (q.fall_cnt < CMD_END) begin
                            d.mosi   = q.cmd_sr[CMD_BITS-1];
                            d.cmd_sr = {q.cmd_sr[CMD_BITS-2:0], 1'b0};
                        end else begin
                            d.mosi = 1'b0;
                        end
                        if (q.fall_cnt > CMD_END) cap_bit = 1'b1;
                        if (q.fall_cnt == LAST_IDX) d.state = ST_WAIT_DONE;
                    end
                end
            end
            ST_WAIT_DONE: begin
                d.sclk = 1'b1;
                d.cnt  = '0;
                if (done_s) begin
                    d.usr_sel = use_usr_clk;
                    d.state   = (use_usr_clk && DELAY_CYCLES > 0) ? ST_DELAY : ST_INIT;
                end
            end
            ST_DELAY: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt + 1'b1 == DLY_END) begin
                    d.cnt   = '0;
                    d.state = ST_INIT;
                end
            end
            ST_INIT: begin
                if (!q.usr_sel || usr_edge) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt + 1'b1 == INIT_END) d.state = ST_USER;
                end
            end
            ST_USER: begin
                d.sclk = 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.sclk     <= 1'b1;
            q.cmd_sr   <= READ_CMD_WORD;
        end else begin
            q <= d;
        end
    end

    assign cs_n      = (q.state == ST_IDLE) || (q.state == ST_USER);
    assign sclk_o    = q.sclk;
    assign sclk_oe   = (q.state != ST_USER);
    assign mosi_o    = q.mosi;
    assign mosi_oe   = (q.state != ST_USER);
    assign done_oe   = (q.state == ST_IDLE) || (q.state == ST_LOAD);
    assign user_mode = (q.state == ST_USER);
endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
    input logic clk,
    input logic rst_n,
    input logic done_in,
    input logic cs_n,
    input logic sclk_o,
    input logic sclk_oe,
    input logic mosi_o,
    input logic mosi_oe,
    input logic done_oe,
    input logic user_mode
);
    assert_sclk_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !cs_n);

    assert_mosi_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mosi_o != $past(mosi_o)) |-> $fell(sclk_o));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_oe |=> !done_oe);

    assert_init_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> $past(done_in));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> (cs_n && !sclk_oe && !mosi_oe && !done_oe));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> user_mode);
endmodule

bind flash_cfg_loader cfgld_checker i_cfgld_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_in   (done_in),
    .cs_n      (cs_n),
    .sclk_o    (sclk_o),
    .sclk_oe   (sclk_oe),
    .mosi_o    (mosi_o),
    .mosi_oe   (mosi_oe),
    .done_oe   (done_oe),
    .user_mode (user_mode)
);

// File: tb/test_flash_cfg_loader.sv
`timescale 1ns/100ps
module test_flash_cfg_loader;
    localparam int NB   = 6;
    localparam int HALF = 2;
    localparam int DLY  = 5;
    localparam int INIT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic use_usr_clk = 1'b0;
    logic usr_clk = 1'b0;
    logic done_in = 1'b0;
    logic miso = 1'b0;
    logic cs_n, sclk_o, sclk_oe, mosi_o, mosi_oe, done_oe, cfg_valid, user_mode;
    logic [7:0] cfg_byte;

    flash_cfg_loader #(
        .NUM_BYTES(NB), .SCLK_HALF(HALF), .DELAY_CYCLES(DLY), .INIT_CYCLES(INIT)
    ) i_flash_cfg_loader (
        .clk(clk), .rst_n(rst_n), .use_usr_clk(use_usr_clk), .usr_clk(usr_clk),
        .done_in(done_in), .miso(miso), .cs_n(cs_n), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .done_oe(done_oe),
        .cfg_byte(cfg_byte), .cfg_valid(cfg_valid), .user_mode(user_mode)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int hcyc = 0;
    int seed_cur = 0;
    int rises = 0;
    int falls = 0;
    int didx = 0;
    int bidx = 0;
    int prev_stamp = 0;
    int period = 0;
    logic [31:0] cmd_rx = '0;

    function automatic logic [7:0] exp_byte(input int sd, input int i);
        if (sd == 2) return (i % 2 == 0) ? 8'h00 : 8'hFF;
        return 8'((i * 37 + sd * 91 + 90) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        hcyc++;
        if (hcyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", hcyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // flash model: samples command on rising edges, returns data on falling edges
    always @(posedge sclk_o) begin
        if (rst_n && !cs_n) begin
            if (rises < 32) cmd_rx = {cmd_rx[30:0], mosi_o};
            rises++;
        end
    end

    always @(negedge sclk_o) begin
        if (rst_n && !cs_n) begin
            falls++;
            if (falls == 4) period = hcyc - prev_stamp;
            prev_stamp = hcyc;
            if (rises >= 32 && didx < NB * 8) begin
                miso = exp_byte(seed_cur, didx / 8)[7 - (didx % 8)];
                didx++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cfg_valid) begin
            chk(bidx < NB && cfg_byte == exp_byte(seed_cur, bidx), "R4 byte value",
                cfg_byte, exp_byte(seed_cur, bidx));
            bidx++;
        end
    end

    task automatic usr_pulse();
        usr_clk = 1'b1;
        repeat (3) @(negedge clk);
        usr_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int sd, input bit usr);
        rst_n = 1'b0; done_in = 1'b0; usr_clk = 1'b0; use_usr_clk = usr;
        seed_cur = sd; rises = 0; falls = 0; didx = 0; bidx = 0; miso = 1'b0;
        cmd_rx = '0; period = 0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R2 cs_n in reset", cs_n, 1);
        chk(done_oe == 1'b1, "R5 done pulled in reset", done_oe, 1);
        chk({user_mode, cfg_valid, sclk_o} == 3'b001, "R10 reset outputs",
            {user_mode, cfg_valid, sclk_o}, 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b0, "R2 cs_n during load", cs_n, 0);
        for (int i = 0; i < 4000 && done_oe; i++) begin
            @(negedge clk);
            if (usr && (i % 3 == 0)) usr_clk = ~usr_clk;
        end
        usr_clk = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_oe == 1'b0, "R5 done released", done_oe, 0);
        chk(cmd_rx == 32'h03000000, "R3 command word", cmd_rx, 32'h03000000);
        chk(bidx == NB, "R4 byte count", bidx, NB);
        chk(didx == NB * 8, "R4 bits served", didx, NB * 8);
        chk(period == 2 * HALF, "R1 sclk period", period, 2 * HALF);
        repeat (40) @(negedge clk);
        chk(user_mode == 1'b0 && cs_n == 1'b0, "R6 waits for done high",
            {user_mode, cs_n}, 2'b00);
        done_in = 1'b1;
        if (!usr) begin
            repeat (2 + INIT) @(negedge clk);
            chk(user_mode == 1'b0, "R7 one cycle early", user_mode, 0);
            @(negedge clk);
            chk(user_mode == 1'b1, "R7 exact cycle", user_mode, 1);
        end else begin
            repeat (2) @(negedge clk);
            usr_clk = 1'b1;
            repeat (2) @(negedge clk);
            usr_clk = 1'b0;
            repeat (DLY + 6) @(negedge clk);
            chk(user_mode == 1'b0, "R8 after delay", user_mode, 0);
            for (int k = 0; k < INIT - 1; k++) usr_pulse();
            repeat (6) @(negedge clk);
            chk(user_mode == 1'b0, "R8 one edge short", user_mode, 0);
            usr_pulse();
            repeat (6) @(negedge clk);
            chk(user_mode == 1'b1, "R8 full count", user_mode, 1);
        end
        chk({cs_n, sclk_oe, mosi_oe} == 3'b100, "R9 pads released",
            {cs_n, sclk_oe, mosi_oe}, 3'b100);
        repeat (10) @(negedge clk);
        chk(user_mode == 1'b1, "R9 user mode sticky", user_mode, 1);
    endtask

    initial begin
        for (int sd = 0; sd < 4; sd++) begin
            run(sd, 1'b0);
            run(sd, 1'b1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule